// File: doc/BRIEF.md
# Configurable GPIO Bank with Pad Hold

A bank of general-purpose pins, each with its own configuration in a small register file. Software reads every pin through a two-flop synchronizer. A pin can raise a sticky interrupt on a rising edge, a falling edge, either edge, or a high or low level. It can also raise a wake request, which responds to a level only. Each pin drives its pad either push-pull or open-drain. The driven value comes from a software data bit or from a shared first-order sigma-delta modulator that has a programmable clock prescaler.

A per-pin hold bit freezes the pad data and the pad enable at the values they had just before hold was applied, so that the pad state survives while the registers behind it change. Pull control gives a pull-up on every pin except one designated pin, which takes a pull-down. Pin multiplexing and the analog pad cells sit outside this block.

Register map (address on `bus_addr`, pin i in data bit i): 0x0 output data, 0x1 output enable, 0x2 open-drain select, 0x3 source select (1 = modulator), 0x4 synchronized pin value (read-only), 0x5 interrupt enable, 0x6 level mode (1 = level, 0 = edge), 0x7 polarity (1 = high level or rising edge), 0x8 both-edges, 0x9 interrupt status (write 1 to clear), 0xA wake enable, 0xB wake polarity (1 = wake on high), 0xC hold, 0xD pull enable, 0xE modulator config (bits 7:0 density, bits 15:8 prescale). Writes take effect at the clock edge where `bus_we` is high. Reads are combinational.

Top module: `gpio_bank`

## Requirements
- R1: After reset, pad_oe, irq and wake are all zero. The pull-enable register reads all ones, so pull_up is set on every pin except pin 16 and pull_dn is set only on pin 16.
- R2: A level applied on pad_in appears in register 0x4 after two rising clock edges.
- R3: A pin whose output enable is set, with open-drain and hold clear, drives pad_out with its data bit and holds pad_oe high. With the enable clear, pad_oe is low.
- R4: In open-drain mode, data 1 releases the pad (pad_oe low) and data 0 drives it low (pad_oe high, pad_out 0). The bank never drives an open-drain pin high.
- R5: A pin with source select 1 outputs the modulator bitstream. An 8-bit accumulator adds the density D once per tick, and each carry-out gives a one, so a full period has D ones for every 256 ticks.
- R6: The modulator ticks once every P+1 clocks, where P is the prescale value, and each output bit lasts for one tick.
- R7: In edge mode, a pad transition sets the status bit on the third rising edge after the change, but only for enabled pins. Polarity 1 selects rising edges, polarity 0 selects falling edges, and the both-edges bit accepts either edge.
- R8: Status bits are sticky and clear only when 1 is written to 0x9. A bit in level mode that still sees its active level sets again despite the clear.
- R9: irq is high exactly when some status bit is set on a pin with interrupt enable set.
- R10: wake is high while any wake-enabled pin has a synchronized level equal to its wake polarity. Wake does not depend on the edge configuration.
- R11: While a pin's hold bit is set, its pad_out and pad_oe keep the values from just before hold was set. Clearing hold returns them to live values.
- R12: Clearing a pin's pull-enable bit removes both pulls on that pin. A pin never has pull_up and pull_dn asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 17 | Pad input levels |
| pad_out | output | 17 | Pad output data |
| pad_oe | output | 17 | Pad output enable |
| pull_up | output | 17 | Pull-up request per pin |
| pull_dn | output | 17 | Pull-down request per pin |
| irq | output | 1 | Combined interrupt |
| wake | output | 1 | Level wake request |

## Verification
Two conditions are hard to reach from the ports. The first is the race between a write-1-to-clear and a level interrupt whose level is still present. The second is a hold that must survive later writes to the data and enable registers. The bench raises a level, waits until the status bit is set, and issues the clear while the level is still present, so that set and clear meet on the same edge. Only after the pad drops does it clear again and expect zero. For hold, it sets the pin driving high, applies hold, and then rewrites both data and enable to the opposite values before it samples the pad.

// File: rtl/gpio_pkg.sv
// Shared register addresses for the GPIO bank.
// Assumes a 4-bit word address on the register port.
package gpio_pkg;
    typedef enum logic [3:0] {
        A_DOUT  = 4'h0,
        A_OEN   = 4'h1,
        A_ODRN  = 4'h2,
        A_SRC   = 4'h3,
        A_PIN   = 4'h4,
        A_IEN   = 4'h5,
        A_ILVL  = 4'h6,
        A_IPOL  = 4'h7,
        A_IANY  = 4'h8,
        A_ISTAT = 4'h9,
        A_WEN   = 4'hA,
        A_WPOL  = 4'hB,
        A_HOLD  = 4'hC,
        A_PULL  = 4'hD,
        A_SDCFG = 4'hE
    } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop input synchronizer plus one delay stage for edge detection.
// Assumes pad_in is asynchronous. Outputs are registered or decoded from registers.
module gpio_in_sync #(
    parameter int N = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pad_in,
    output logic [N-1:0] pin_q,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] s1_q, s2_q, s3_q;

    // Purpose: sync chain and previous-value stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= pad_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign pin_q = s2_q;
    assign rise  = s2_q & ~s3_q;
    assign fall  = ~s2_q & s3_q;
endmodule

// File: rtl/gpio_sigma_delta.sv
// First-order sigma-delta modulator: accumulator carry-out is the bitstream.
// A prescaler gives one tick every presc+1 clocks; the bit holds between ticks.
module gpio_sigma_delta #(
    parameter int ACC_W = 8,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] duty,
    input  logic [PRE_W-1:0] presc,
    output logic             bit_o
);
    logic [PRE_W-1:0] cnt_q;
    logic [ACC_W-1:0] acc_q;
    logic             bit_q;
    logic             tick;
    logic [ACC_W:0]   sum;

    assign tick = (cnt_q >= presc);
    assign sum  = {1'b0, acc_q} + {1'b0, duty};

    // Purpose: prescaler counter
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // Purpose: accumulate and register the carry on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            bit_q <= 1'b0;
        end else if (tick) begin
            acc_q <= sum[ACC_W-1:0];
            bit_q <= sum[ACC_W];
        end
    end

    assign bit_o = bit_q;
endmodule

// File: rtl/gpio_pad_drive.sv
// Per-pin output path: source mux, push-pull/open-drain, hold latch, pulls.
// Held copies track live values while hold is clear and freeze while it is set.
module gpio_pad_drive #(
    parameter int N      = 17,
    parameter int PD_PIN = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] dout,
    input  logic [N-1:0] oen,
    input  logic [N-1:0] odrn,
    input  logic [N-1:0] src,
    input  logic         sd_bit,
    input  logic [N-1:0] hold,
    input  logic [N-1:0] pullen,
    output logic [N-1:0] pad_out,
    output logic [N-1:0] pad_oe,
    output logic [N-1:0] pull_up,
    output logic [N-1:0] pull_dn
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic data, live_out, live_oe, held_out_q, held_oe_q;

        assign data     = src[i] ? sd_bit : dout[i];
        assign live_out = odrn[i] ? 1'b0 : data;
        assign live_oe  = odrn[i] ? (oen[i] & ~data) : oen[i];

        // Purpose: capture pad state while not holding
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_out_q <= 1'b0;
                held_oe_q  <= 1'b0;
            end else if (!hold[i]) begin
                held_out_q <= live_out;
                held_oe_q  <= live_oe;
            end
        end

        assign pad_out[i] = hold[i] ? held_out_q : live_out;
        assign pad_oe[i]  = hold[i] ? held_oe_q  : live_oe;
        if (i == PD_PIN) begin : g_dn
            assign pull_up[i] = 1'b0;
            assign pull_dn[i] = pullen[i];
        end else begin : g_up
            assign pull_up[i] = pullen[i];
            assign pull_dn[i] = 1'b0;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
// GPIO bank top: register file, interrupt status, wake, and submodule wiring.
// Assumes N <= 32; single-cycle writes, combinational reads.
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int N      = 17,
    parameter int PD_PIN = 16,
    parameter int SD_W   = 8,
    parameter int PRE_W  = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_we,
    input  logic [3:0]   bus_addr,
    input  logic [31:0]  bus_wdata,
    output logic [31:0]  bus_rdata,
    input  logic [N-1:0] pad_in,
    output logic [N-1:0] pad_out,
    output logic [N-1:0] pad_oe,
    output logic [N-1:0] pull_up,
    output logic [N-1:0] pull_dn,
    output logic         irq,
    output logic         wake
);
    localparam int CFG_W = SD_W + PRE_W;

    logic [N-1:0] dout_q, oen_q, odrn_q, src_q, ien_q, ilvl_q, ipol_q, iany_q;
    logic [N-1:0] stat_q, wen_q, wpol_q, hold_q, pullen_q;
    logic [SD_W-1:0]  duty_q;
    logic [PRE_W-1:0] presc_q;
    logic [N-1:0] pin_q, rise, fall, wdat, clr, set_v, lvl_hit, edge_hit;
    logic         sd_bit;

    assign wdat = bus_wdata[N-1:0];

    // Purpose: configuration register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0; oen_q <= '0; odrn_q <= '0; src_q <= '0;
            ien_q <= '0; ilvl_q <= '0; ipol_q <= '0; iany_q <= '0;
            wen_q <= '0; wpol_q <= '0; hold_q <= '0; pullen_q <= '1;
            duty_q <= '0; presc_q <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                A_DOUT:  dout_q   <= wdat;
                A_OEN:   oen_q    <= wdat;
                A_ODRN:  odrn_q   <= wdat;
                A_SRC:   src_q    <= wdat;
                A_IEN:   ien_q    <= wdat;
                A_ILVL:  ilvl_q   <= wdat;
                A_IPOL:  ipol_q   <= wdat;
                A_IANY:  iany_q   <= wdat;
                A_WEN:   wen_q    <= wdat;
                A_WPOL:  wpol_q   <= wdat;
                A_HOLD:  hold_q   <= wdat;
                A_PULL:  pullen_q <= wdat;
                A_SDCFG: begin
                    duty_q  <= bus_wdata[SD_W-1:0];
                    presc_q <= bus_wdata[SD_W +: PRE_W];
                end
                default: ;
            endcase
        end
    end

    assign clr      = (bus_we && bus_addr == A_ISTAT) ? wdat : '0;
    assign lvl_hit  = ~(pin_q ^ ipol_q);
    assign edge_hit = (rise & (ipol_q | iany_q)) | (fall & (~ipol_q | iany_q));
    assign set_v    = ien_q & ((ilvl_q & lvl_hit) | (~ilvl_q & edge_hit));

    // Purpose: sticky status, set wins over write-one-clear
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr) | set_v;
    end

    assign irq  = |(stat_q & ien_q);
    assign wake = |(wen_q & ~(pin_q ^ wpol_q));

    // Purpose: register read mux
    always_comb begin
        case (bus_addr)
            A_DOUT:  bus_rdata = 32'(dout_q);
            A_OEN:   bus_rdata = 32'(oen_q);
            A_ODRN:  bus_rdata = 32'(odrn_q);
            A_SRC:   bus_rdata = 32'(src_q);
            A_PIN:   bus_rdata = 32'(pin_q);
            A_IEN:   bus_rdata = 32'(ien_q);
            A_ILVL:  bus_rdata = 32'(ilvl_q);
            A_IPOL:  bus_rdata = 32'(ipol_q);
            A_IANY:  bus_rdata = 32'(iany_q);
            A_ISTAT: bus_rdata = 32'(stat_q);
            A_WEN:   bus_rdata = 32'(wen_q);
            A_WPOL:  bus_rdata = 32'(wpol_q);
            A_HOLD:  bus_rdata = 32'(hold_q);
            A_PULL:  bus_rdata = 32'(pullen_q);
            A_SDCFG: bus_rdata = 32'({presc_q, duty_q});
            default: bus_rdata = '0;
        endcase
    end

    gpio_in_sync #(.N(N)) sync_i (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
        .pin_q(pin_q), .rise(rise), .fall(fall)
    );

    gpio_sigma_delta #(.ACC_W(SD_W), .PRE_W(PRE_W)) sd_i (
        .clk(clk), .rst_n(rst_n), .duty(duty_q), .presc(presc_q), .bit_o(sd_bit)
    );

    gpio_pad_drive #(.N(N), .PD_PIN(PD_PIN)) drv_i (
        .clk(clk), .rst_n(rst_n), .dout(dout_q), .oen(oen_q), .odrn(odrn_q),
        .src(src_q), .sd_bit(sd_bit), .hold(hold_q), .pullen(pullen_q),
        .pad_out(pad_out), .pad_oe(pad_oe), .pull_up(pull_up), .pull_dn(pull_dn)
    );
endmodule

// File: rtl/gpio_bank_chk.sv
// Property checker for gpio_bank, bound to every instance of the top.
// Observes ports and configuration state through bind connections.
module gpio_bank_chk #(
    parameter int N = 17
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_we,
    input logic [3:0]   bus_addr,
    input logic [31:0]  bus_wdata,
    input logic [N-1:0] pad_out,
    input logic [N-1:0] pad_oe,
    input logic [N-1:0] pull_up,
    input logic [N-1:0] pull_dn,
    input logic         irq,
    input logic [N-1:0] stat_q,
    input logic [N-1:0] ien_q,
    input logic [N-1:0] oen_q,
    input logic [N-1:0] odrn_q,
    input logic [N-1:0] hold_q
);
    logic [N-1:0] clr_v;
    assign clr_v = (bus_we && bus_addr == 4'h9) ? bus_wdata[N-1:0] : '0;

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (odrn_q & ~hold_q & pad_oe & pad_out) == '0); // R4
    AST_OE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (~oen_q & ~hold_q & pad_oe) == '0); // R3
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out ^ $past(pad_out)) | (pad_oe ^ $past(pad_oe))) & hold_q & $past(hold_q)) == '0); // R11
    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_q) & ~$past(clr_v)) & ~stat_q) == '0); // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq); // R9
    AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_up & pull_dn) == '0); // R12
endmodule

bind gpio_bank gpio_bank_chk #(.N(N)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pad_out(pad_out), .pad_oe(pad_oe),
    .pull_up(pull_up), .pull_dn(pull_dn), .irq(irq), .stat_q(stat_q),
    .ien_q(ien_q), .oen_q(oen_q), .odrn_q(odrn_q), .hold_q(hold_q)
);

// File: tb/gpio_bank_tb_top.sv
`timescale 1ns/1ps
// Directed bench for gpio_bank: one task per scenario, each checks itself.
module gpio_bank_tb_top;
    localparam int N = 17;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe, pull_up, pull_dn;
    logic         irq, wake;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pull_up(pull_up),
        .pull_dn(pull_dn), .irq(irq), .wake(wake)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 pad_oe", 32'(pad_oe), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 wake", 32'(wake), 32'h0);
        check("R1 pull_up", 32'(pull_up), 32'h0FFFF);
        check("R1 pull_dn", 32'(pull_dn), 32'h10000);
        rd(4'hD, d);
        check("R1 pull reg", d, 32'h1FFFF);
    endtask

    task automatic t_input();
        logic [31:0] d;
        pad_in = 17'h0A5A5;
        tick(1);
        rd(4'h4, d);
        check("R2 not yet after one edge", d, 32'h0);
        tick(1);
        rd(4'h4, d);
        check("R2 pin value", d, 32'h0A5A5);
        pad_in = '0;
        tick(3);
    endtask

    task automatic t_push_pull();
        wr(4'h1, 32'h1FFFF);
        wr(4'h0, 32'h13C0F);
        check("R3 pad_out", 32'(pad_out), 32'h13C0F);
        check("R3 pad_oe", 32'(pad_oe), 32'h1FFFF);
        wr(4'h1, 32'h000FF);
        check("R3 oe disabled", 32'(pad_oe), 32'h000FF);
    endtask

    task automatic t_open_drain();
        wr(4'h1, 32'h1FFFF);
        wr(4'h2, 32'h1FFFF);
        wr(4'h0, 32'h0F0F0);
        check("R4 pad_oe", 32'(pad_oe), 32'h10F0F);
        check("R4 pad_out", 32'(pad_out), 32'h0);
        wr(4'h2, 32'h0);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_sigma(logic [7:0] duty, logic [7:0] presc, int cycles, int exp, string tag);
        int ones = 0;
        wr(4'h1, 32'h00080);
        wr(4'h3, 32'h00080);
        wr(4'hE, {16'h0, presc, duty});
        tick(16);
        for (int i = 0; i < cycles; i++) begin
            if (pad_out[7]) ones++;
            tick(1);
        end
        check(tag, 32'(ones), 32'(exp));
        wr(4'hE, 32'h0);
        wr(4'h3, 32'h0);
        tick(4);
    endtask

    task automatic t_edges();
        logic [31:0] d;
        wr(4'h5, 32'h00025);
        wr(4'h6, 32'h0);
        wr(4'h7, 32'h00001);
        wr(4'h8, 32'h00020);
        pad_in[0] = 1'b1;
        tick(2);
        check("R7 rise not yet", 32'(irq), 32'h0);
        tick(1);
        rd(4'h9, d);
        check("R7 rise status", d, 32'h00001);
        check("R9 irq on", 32'(irq), 32'h1);
        wr(4'h9, 32'h00001);
        rd(4'h9, d);
        check("R8 w1c cleared", d, 32'h0);
        check("R9 irq off", 32'(irq), 32'h0);
        pad_in[2] = 1'b1;
        tick(4);
        rd(4'h9, d);
        check("R7 rise ignored on falling pin", d, 32'h0);
        pad_in[2] = 1'b0;
        tick(4);
        rd(4'h9, d);
        check("R7 falling status", d, 32'h00004);
        wr(4'h9, 32'h1FFFF);
        pad_in[5] = 1'b1;
        tick(4);
        rd(4'h9, d);
        check("R7 both rise", d, 32'h00020);
        wr(4'h9, 32'h1FFFF);
        pad_in[5] = 1'b0;
        tick(4);
        rd(4'h9, d);
        check("R7 both fall", d, 32'h00020);
        wr(4'h9, 32'h1FFFF);
        pad_in[8] = 1'b1;
        tick(4);
        rd(4'h9, d);
        check("R7 disabled pin", d, 32'h0);
        pad_in = '0;
        tick(4);
        wr(4'h9, 32'h1FFFF);
        wr(4'h5, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(4'h5, 32'h00002);
        wr(4'h6, 32'h00002);
        wr(4'h7, 32'h00002);
        pad_in[1] = 1'b1;
        tick(4);
        rd(4'h9, d);
        check("R8 level set", d, 32'h00002);
        wr(4'h9, 32'h00002);
        rd(4'h9, d);
        check("R8 level re-asserts", d, 32'h00002);
        pad_in[1] = 1'b0;
        tick(4);
        wr(4'h9, 32'h00002);
        rd(4'h9, d);
        check("R8 level gone cleared", d, 32'h0);
        check("R9 irq idle", 32'(irq), 32'h0);
        wr(4'h5, 32'h0);
        wr(4'h6, 32'h0);
        wr(4'h7, 32'h0);
    endtask

    task automatic t_wake();
        wr(4'hB, 32'h00008);
        check("R10 no wake disabled", 32'(wake), 32'h0);
        wr(4'hA, 32'h00008);
        check("R10 level low no wake", 32'(wake), 32'h0);
        pad_in[3] = 1'b1;
        tick(1);
        check("R10 before sync", 32'(wake), 32'h0);
        tick(1);
        check("R10 wake high", 32'(wake), 32'h1);
        wr(4'hB, 32'h0);
        check("R10 polarity flip", 32'(wake), 32'h0);
        pad_in[3] = 1'b0;
        tick(2);
        check("R10 low wake", 32'(wake), 32'h1);
        wr(4'hA, 32'h0);
        check("R10 disable", 32'(wake), 32'h0);
    endtask

    task automatic t_hold();
        wr(4'h1, 32'h00200);
        wr(4'h0, 32'h00200);
        wr(4'hC, 32'h00200);
        wr(4'h0, 32'h0);
        wr(4'h1, 32'h0);
        tick(3);
        check("R11 held out", 32'(pad_out[9]), 32'h1);
        check("R11 held oe", 32'(pad_oe[9]), 32'h1);
        wr(4'hC, 32'h0);
        check("R11 released out", 32'(pad_out[9]), 32'h0);
        check("R11 released oe", 32'(pad_oe[9]), 32'h0);
    endtask

    task automatic t_pull();
        wr(4'hD, 32'h10001);
        check("R12 pull_up", 32'(pull_up), 32'h00001);
        check("R12 pull_dn", 32'(pull_dn), 32'h10000);
        wr(4'hD, 32'h0);
        check("R12 none", 32'(pull_up | pull_dn), 32'h0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_input();
        t_push_pull();
        t_open_drain();
        t_sigma(8'd64, 8'd0, 256, 64, "R5 density");
        t_sigma(8'd64, 8'd3, 1024, 256, "R6 prescaled");
        t_edges();
        t_level();
        t_wake();
        t_hold();
        t_pull();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule